// File: doc/BRIEF.md
# Adaptive Victim Write-Back Router

This block sits at the eviction port of one shared second-level cache. Each line that the cache victimizes comes in with its line address, a dirty flag and a signal saying whether a peer on-chip second-level cache has room to take a line. The block registers a routing decision for that line: send it to the third-level victim cache, hand it to the peer cache, or drop it silently.

Two small direct-mapped hint tables drive the decision. A residency table remembers lines believed to already sit in the third-level cache, so that clean victims with a copy there are not written back a second time. A reuse table remembers lines that came back after an earlier eviction, so that such lines are kept on chip in a peer cache when one has room. Both tables are trained from outside through set and clear ports. A hint may be stale or aliased. That only costs performance, because a dirty line is never dropped.

The decision comes out one cycle after the victim is accepted. It is held in place until the consumer takes it, using a valid/ready handshake on each side.

Top module: `victim_wb_router`

## Requirements
- R1: After reset `dec_valid` is 0, `vic_ready` is 1 and both tables are empty, so a clean untrained victim is routed to the third-level cache (`dec_dest` = 2'b01).
- R2: A dirty victim is never dropped. Without a peer-steering decision it goes to the third-level cache (2'b01).
- R3: A clean victim whose residency lookup hits is dropped (2'b00). A clean victim whose residency lookup misses goes to the third-level cache (2'b01).
- R4: A victim whose reuse lookup hits, while `peer_room` is 1, is sent to the peer cache (2'b10). This holds whether the victim is clean or dirty.
- R5: When `peer_room` is 0, or the reuse lookup misses, the victim never goes to the peer cache. It follows the rules of R2 and R3 instead.
- R6: A reuse hit with `peer_room` set wins over a residency hit, so such a clean line goes to the peer cache (2'b10).
- R7: Each table has 2^IDX_W entries. The index is address bits [IDX_W-1:0] and the partial tag is bits [IDX_W+TAG_W-1:IDX_W]. A lookup hits only on a valid entry with an equal tag, so an alias at the same index misses.
- R8: A clear request invalidates the indexed entry only when the stored tag equals the tag of the cleared address.
- R9: A victim looked up in the same cycle as a table update to the same index sees the table as it was before that update.
- R10: The decision appears on `dec_valid` one clock after `vic_valid && vic_ready`. While `dec_valid && !dec_ready`, the decision is held stable and `vic_ready` is 0.
- R11: A set and a clear that reach the same entry of the same table in the same cycle leave the entry set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vic_valid | input | 1 | A victim line is offered |
| vic_ready | output | 1 | The router can take a victim this cycle |
| vic_addr | input | ADDR_W | Line address of the victim |
| vic_dirty | input | 1 | The victim is modified |
| peer_room | input | 1 | A peer second-level cache can accept a line |
| res_set_valid | input | 1 | Mark a line as resident in the third-level cache |
| res_set_key | input | IDX_W+TAG_W | Low line-address bits of the line to mark |
| res_clr_valid | input | 1 | Invalidate notice from the third-level cache |
| res_clr_key | input | IDX_W+TAG_W | Low line-address bits of the invalidated line |
| reu_set_valid | input | 1 | An earlier victim was referenced again |
| reu_set_key | input | IDX_W+TAG_W | Low line-address bits of that line |
| reu_clr_valid | input | 1 | The line was evicted from a peer cache |
| reu_clr_key | input | IDX_W+TAG_W | Low line-address bits of that line |
| dec_valid | output | 1 | A routing decision is presented |
| dec_ready | input | 1 | The consumer takes the decision |
| dec_dest | output | 2 | 00 drop, 01 third-level cache, 10 peer cache |
| dec_addr | output | ADDR_W | Address of the routed victim |
| dec_dirty | output | 1 | Dirty flag of the routed victim |

## Verification
Victims are offered in each combination of dirty flag, `peer_room`, residency hit and reuse hit. These cases separate the peer path, the write-back path and the drop path, and show that reuse wins over residency. Aliased addresses at a shared index, and clears whose tag does not match, show whether the partial tag takes part in both lookup and invalidation. Updates made in the same cycle as a lookup, and set/clear collisions, pin down the ordering at the table edge. A stalled consumer shows that the decision is held and that new victims are refused.

// File: rtl/victim_wb_router.sv
module victim_wb_router #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 8,
  localparam int KEY_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vic_valid,
  output logic              vic_ready,
  input  logic [ADDR_W-1:0] vic_addr,
  input  logic              vic_dirty,
  input  logic              peer_room,
  input  logic              res_set_valid,
  input  logic [KEY_W-1:0]  res_set_key,
  input  logic              res_clr_valid,
  input  logic [KEY_W-1:0]  res_clr_key,
  input  logic              reu_set_valid,
  input  logic [KEY_W-1:0]  reu_set_key,
  input  logic              reu_clr_valid,
  input  logic [KEY_W-1:0]  reu_clr_key,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [1:0]        dec_dest,
  output logic [ADDR_W-1:0] dec_addr,
  output logic              dec_dirty
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] DST_DROP = 2'b00;
  localparam logic [1:0] DST_L3   = 2'b01;
  localparam logic [1:0] DST_PEER = 2'b10;

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [1:0]       hit;
  logic [1:0]       set_v, clr_v;
  logic [KEY_W-1:0] set_key [2];
  logic [KEY_W-1:0] clr_key [2];
  logic [1:0]       dest_nxt;
  logic             take;

  assign lk_idx = vic_addr[IDX_W-1:0];
  assign lk_tag = vic_addr[KEY_W-1:IDX_W];

  assign set_v      = {reu_set_valid, res_set_valid};
  assign clr_v      = {reu_clr_valid, res_clr_valid};
  assign set_key[0] = res_set_key;
  assign set_key[1] = reu_set_key;
  assign clr_key[0] = res_clr_key;
  assign clr_key[1] = reu_clr_key;

  // table 0: residency hints, table 1: reuse hints
  for (genvar t = 0; t < 2; t++) begin : g_tab
    logic [DEPTH-1:0] vld;
    logic [TAG_W-1:0] tg [DEPTH];
    logic [IDX_W-1:0] s_idx, c_idx;
    logic [TAG_W-1:0] s_tag, c_tag;

    assign s_idx = set_key[t][IDX_W-1:0];
    assign s_tag = set_key[t][KEY_W-1:IDX_W];
    assign c_idx = clr_key[t][IDX_W-1:0];
    assign c_tag = clr_key[t][KEY_W-1:IDX_W];
    assign hit[t] = vld[lk_idx] && (tg[lk_idx] == lk_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= '0;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (set_v[t] && s_idx == IDX_W'(i))
            vld[i] <= 1'b1;
          else if (clr_v[t] && c_idx == IDX_W'(i) && tg[i] == c_tag)
            vld[i] <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++)
        if (set_v[t] && s_idx == IDX_W'(i)) tg[i] <= s_tag;
    end
  end

  assign dest_nxt = (hit[1] && peer_room)     ? DST_PEER :
                    (vic_dirty || !hit[0])    ? DST_L3   : DST_DROP;

  assign vic_ready = !dec_valid || dec_ready;
  assign take      = vic_valid && vic_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_valid <= 1'b0;
    else if (vic_ready) dec_valid <= vic_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_dest  <= DST_DROP;
      dec_addr  <= '0;
      dec_dirty <= 1'b0;
    end else if (take) begin
      dec_dest  <= dest_nxt;
      dec_addr  <= vic_addr;
      dec_dirty <= vic_dirty;
    end
  end

  AST_DIRTY_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !(dec_dirty && dec_dest == DST_DROP)); // R2
  AST_PEER_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !peer_room) |=> dec_dest != DST_PEER); // R5
  AST_DEST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> dec_dest != 2'b11); // R4
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> dec_valid && $stable(dec_dest) && $stable(dec_addr)); // R10
  AST_REFUSE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !vic_ready); // R10
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> dec_valid); // R10
endmodule

// File: tb/victim_wb_router_bench.sv
module victim_wb_router_bench;
  localparam int ADDR_W = 32, IDX_W = 6, TAG_W = 8, KEY_W = IDX_W + TAG_W;

  logic clk = 0, rst_n = 0;
  logic vic_valid = 0, vic_dirty = 0, peer_room = 0, dec_ready = 1;
  logic [ADDR_W-1:0] vic_addr = '0;
  logic res_set_valid = 0, res_clr_valid = 0, reu_set_valid = 0, reu_clr_valid = 0;
  logic [KEY_W-1:0] res_set_key = '0, res_clr_key = '0, reu_set_key = '0, reu_clr_key = '0;
  logic vic_ready, dec_valid, dec_dirty;
  logic [1:0] dec_dest;
  logic [ADDR_W-1:0] dec_addr;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  victim_wb_router #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_victim_wb_router (
    .clk, .rst_n, .vic_valid, .vic_ready, .vic_addr, .vic_dirty, .peer_room,
    .res_set_valid, .res_set_key, .res_clr_valid, .res_clr_key,
    .reu_set_valid, .reu_set_key, .reu_clr_valid, .reu_clr_key,
    .dec_valid, .dec_ready, .dec_dest, .dec_addr, .dec_dirty);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic send(logic [31:0] a, logic d, logic room, logic [1:0] exp, string req);
    @(negedge clk);
    vic_valid = 1; vic_addr = a; vic_dirty = d; peer_room = room;
    @(negedge clk);
    vic_valid = 0;
    chk({req, " valid"}, 32'(dec_valid), 1);
    chk({req, " dest"}, 32'(dec_dest), 32'(exp));
  endtask

  task automatic res_set(logic [31:0] a);
    @(negedge clk); res_set_valid = 1; res_set_key = a[KEY_W-1:0];
    @(negedge clk); res_set_valid = 0;
  endtask
  task automatic res_clr(logic [31:0] a);
    @(negedge clk); res_clr_valid = 1; res_clr_key = a[KEY_W-1:0];
    @(negedge clk); res_clr_valid = 0;
  endtask
  task automatic reu_set(logic [31:0] a);
    @(negedge clk); reu_set_valid = 1; reu_set_key = a[KEY_W-1:0];
    @(negedge clk); reu_set_valid = 0;
  endtask
  task automatic reu_clr(logic [31:0] a);
    @(negedge clk); reu_clr_valid = 1; reu_clr_key = a[KEY_W-1:0];
    @(negedge clk); reu_clr_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 dec_valid", 32'(dec_valid), 0);
    chk("R1 vic_ready", 32'(vic_ready), 1);
    send(32'h2A, 0, 1, 2'b01, "R1 empty tables");
  endtask

  task automatic t_residency;
    res_set(32'h105);
    send(32'h105, 0, 0, 2'b00, "R3 clean resident");
    send(32'h105, 1, 0, 2'b01, "R2 dirty resident");
    send(32'h2A, 0, 0, 2'b01, "R3 clean not resident");
    chk("R2 dirty flag", 32'(dec_dirty), 0);
  endtask

  task automatic t_alias;
    send(32'h145, 0, 0, 2'b01, "R7 alias misses");
    res_clr(32'h145);
    send(32'h105, 0, 0, 2'b00, "R8 mismatched clear ignored");
    res_clr(32'h105);
    send(32'h105, 0, 0, 2'b01, "R8 matching clear");
  endtask

  task automatic t_reuse;
    reu_set(32'h3333);
    send(32'h3333, 0, 1, 2'b10, "R4 clean to peer");
    send(32'h3333, 1, 1, 2'b10, "R4 dirty to peer");
    chk("R4 addr", dec_addr, 32'h3333);
    send(32'h3333, 1, 0, 2'b01, "R5 dirty no room");
    send(32'h3333, 0, 0, 2'b01, "R5 clean no room");
    send(32'h0033, 0, 1, 2'b01, "R5 reuse alias no peer");
    res_set(32'h3333);
    send(32'h3333, 0, 1, 2'b10, "R6 reuse over residency");
    send(32'h3333, 0, 0, 2'b00, "R6 no room falls to filter");
    reu_clr(32'h3333);
    send(32'h3333, 0, 1, 2'b00, "R8 reuse cleared");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    vic_valid = 1; vic_addr = 32'h7; vic_dirty = 0; peer_room = 0;
    res_set_valid = 1; res_set_key = 14'h7;
    @(negedge clk);
    vic_valid = 0; res_set_valid = 0;
    chk("R9 old state seen", 32'(dec_dest), 32'(2'b01));
    send(32'h7, 0, 0, 2'b00, "R9 update visible later");
  endtask

  task automatic t_set_clr;
    @(negedge clk);
    res_set_valid = 1; res_set_key = 14'h19;
    res_clr_valid = 1; res_clr_key = 14'h19;
    @(negedge clk);
    res_set_valid = 0; res_clr_valid = 0;
    send(32'h19, 0, 0, 2'b00, "R11 set wins");
  endtask

  task automatic t_handshake;
    @(negedge clk);
    dec_ready = 0;
    vic_valid = 1; vic_addr = 32'h1234; vic_dirty = 1; peer_room = 0;
    @(negedge clk);
    vic_addr = 32'h105; vic_dirty = 0;
    chk("R10 valid after accept", 32'(dec_valid), 1);
    chk("R10 refuse while stalled", 32'(vic_ready), 0);
    @(negedge clk);
    vic_valid = 0;
    chk("R10 held valid", 32'(dec_valid), 1);
    chk("R10 held addr", dec_addr, 32'h1234);
    chk("R10 held dest", 32'(dec_dest), 32'(2'b01));
    dec_ready = 1;
    @(negedge clk);
    chk("R10 drained", 32'(dec_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_residency();
    t_alias();
    t_reuse();
    t_same_cycle();
    t_set_clr();
    t_handshake();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule